// File: doc/BRIEF.md
# Taxi Trip Distance and Waiting Meter

This block keeps the metering part of a taxi trip. A wheel-pulse input marks each 100 m travelled and a minute-tick input marks each minute that passes. Both arrive without relation to the system clock, so each passes through its own synchroniser and rising-edge detector before it can be counted. A trip-active input, sampled on the system clock, holds the whole meter at zero while low. A wait-mode input chooses which source is counted. When it is low, wheel pulses advance the distance. When it is high, minute ticks advance the waiting time.

Distance comes out as three BCD digits: tenths of a kilometre, kilometre ones and kilometre tens. Waiting comes out as two BCD digits of minutes. Two rate-enable flags tell downstream fare logic when the free allowance is used up: 2 km of travel, or 2 minutes of waiting. Each flag shows only in its own mode. Two single-cycle strobes mark each chargeable kilometre and each chargeable minute that completes. The block does no fare arithmetic and drives no display.

Top module: `trip_distance_wait_meter`

## Requirements
- R1: Each rising edge of `dist_pulse_in` or `minute_tick_in` is counted at most once, however long the input then stays high. A count becomes visible on the outputs three clock edges after the input rises. Inputs must stay high and then low for at least two clocks each.
- R2: While `trip_on` is low, every edge clears all digits, both internal allowance records and both strobes. During that time both rate flags read 0.
- R3: While `wait_mode` is high, wheel pulses leave the distance digits unchanged.
- R4: While `wait_mode` is low, minute ticks leave the waiting digits unchanged. While it is high, each tick adds one minute.
- R5: Ten pulses make one kilometre. When a pulse arrives with `dist_tenths` at 9, it wraps to 0 and carries into the kilometre digits on the same edge.
- R6: `dist_km_tens`:`dist_km_ones` counts whole kilometres from 00 to 99 in BCD and wraps to 00 after 99. Every digit stays in the range 0..9.
- R7: `wait_min_tens`:`wait_min_ones` counts minutes from 00 to 59 in BCD and wraps to 00 after 59. The tens digit never exceeds 5.
- R8: `dist_rate_en` is 1 once the distance exceeds 2.0 km, which is from the 21st pulse onward. It stays 1 after the kilometre count wraps. It reads 0 whenever `wait_mode` is high.
- R9: `wait_rate_en` is 1 once the waiting time exceeds 2 minutes, which is from the 3rd tick onward. It stays 1 after the minute count wraps. It reads 0 whenever `wait_mode` is low.
- R10: `km_done` pulses for one cycle for each kilometre completed beyond the first two: one pulse per kilometre from the 3rd onward. `min_done` pulses for one cycle for each minute completed beyond the first two: one pulse per minute from the 3rd onward. The two never pulse together.
- R11: After `rst_n` is asserted low, all digits, flags and strobes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_on | input | 1 | Trip active. Low clears the meter (synchronous to clk) |
| wait_mode | input | 1 | 1 = count waiting minutes, 0 = count distance |
| dist_pulse_in | input | 1 | Asynchronous wheel pulse, one per 100 m |
| minute_tick_in | input | 1 | Asynchronous one-minute tick |
| dist_tenths | output | 4 | BCD tenths of a kilometre |
| dist_km_ones | output | 4 | BCD kilometre ones |
| dist_km_tens | output | 4 | BCD kilometre tens |
| wait_min_ones | output | 4 | BCD waiting minutes, ones |
| wait_min_tens | output | 4 | BCD waiting minutes, tens (0..5) |
| dist_rate_en | output | 1 | Distance allowance used up, shown in driving mode only |
| wait_rate_en | output | 1 | Waiting allowance used up, shown in wait mode only |
| km_done | output | 1 | One-cycle strobe per chargeable kilometre |
| min_done | output | 1 | One-cycle strobe per chargeable minute |

## Verification
Three things can happen on the same edge: the tenths digit wraps, the kilometre digits take the carry, and `km_done` fires. The hardest case is the 1000th pulse of a trip. On that edge, 99.9 km rolls to 00.0, every digit wraps together, and the strobe must still fire even though the distance now reads below the allowance. The bench drives a trip to 99.9 km and then to the wrap. It judges the digits, the retained `dist_rate_en` and the total strobe count against the number of kilometres beyond two that were completed. The same approach runs the waiting counter through its 59-to-00 wrap.

// File: rtl/trip_meter_pkg.sv
package trip_meter_pkg;
  typedef logic [3:0] bcd_t;
  localparam int unsigned DEC_MAX      = 9;
  localparam int unsigned MIN_TENS_MAX = 5;
  localparam int unsigned DIST_DIGITS  = 3;
  localparam int unsigned WAIT_DIGITS  = 2;
endpackage

// File: rtl/trip_edge_sync.sv
module trip_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // R1: a detected rise lasts exactly one cycle
  a_r1_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/trip_bcd_digit.sv
module trip_bcd_digit
  import trip_meter_pkg::*;
#(
  parameter int unsigned MAX = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output bcd_t val,
  output logic wrap
);
  localparam bcd_t TOP = bcd_t'(MAX);

  assign wrap = inc && (val == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val <= '0;
    else if (clr)  val <= '0;
    else if (inc)  val <= wrap ? '0 : val + 4'd1;
  end

  // R6 / R7: a digit never leaves its range
  a_r6_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    val <= TOP);
endmodule

// File: rtl/trip_distance_wait_meter.sv
module trip_distance_wait_meter
  import trip_meter_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FREE_KM     = 2,
  parameter int unsigned FREE_MIN    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_on,
  input  logic       wait_mode,
  input  logic       dist_pulse_in,
  input  logic       minute_tick_in,
  output logic [3:0] dist_tenths,
  output logic [3:0] dist_km_ones,
  output logic [3:0] dist_km_tens,
  output logic [3:0] wait_min_ones,
  output logic [3:0] wait_min_tens,
  output logic       dist_rate_en,
  output logic       wait_rate_en,
  output logic       km_done,
  output logic       min_done
);
  localparam logic [9:0] FREE_TENTHS_V = 10'(FREE_KM * 10);
  localparam logic [5:0] FREE_MIN_V    = 6'(FREE_MIN);

  logic dist_rise, tick_rise;
  logic dist_inc, wait_inc, clr;
  logic [DIST_DIGITS:0] dist_carry;
  logic [WAIT_DIGITS:0] wait_carry;
  bcd_t dist_dig [DIST_DIGITS];
  bcd_t wait_dig [WAIT_DIGITS];
  logic [9:0] dist_total;
  logic [5:0] wait_total;
  logic dist_over, wait_over, wait_at_free;
  logic dist_used_q, wait_used_q, km_done_q, min_done_q;

  trip_edge_sync #(.STAGES(SYNC_STAGES)) u_dist_sync (
    .clk(clk), .rst_n(rst_n), .din(dist_pulse_in), .rise(dist_rise));
  trip_edge_sync #(.STAGES(SYNC_STAGES)) u_tick_sync (
    .clk(clk), .rst_n(rst_n), .din(minute_tick_in), .rise(tick_rise));

  assign clr      = ~trip_on;
  assign dist_inc = trip_on & ~wait_mode & dist_rise;
  assign wait_inc = trip_on &  wait_mode & tick_rise;
  assign dist_carry[0] = dist_inc;
  assign wait_carry[0] = wait_inc;

  generate
    for (genvar g = 0; g < DIST_DIGITS; g++) begin : g_dist
      trip_bcd_digit #(.MAX(DEC_MAX)) u_digit (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(dist_carry[g]),
        .val(dist_dig[g]), .wrap(dist_carry[g+1]));
    end
    for (genvar g = 0; g < WAIT_DIGITS; g++) begin : g_wait
      trip_bcd_digit #(.MAX((g == WAIT_DIGITS-1) ? MIN_TENS_MAX : DEC_MAX)) u_digit (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(wait_carry[g]),
        .val(wait_dig[g]), .wrap(wait_carry[g+1]));
    end
  endgenerate

  always_comb begin
    dist_total = 10'(dist_dig[2]) * 10'd100 + 10'(dist_dig[1]) * 10'd10
               + 10'(dist_dig[0]);
    wait_total = 6'(wait_dig[1]) * 6'd10 + 6'(wait_dig[0]);
  end

  assign dist_over    = dist_total > FREE_TENTHS_V;
  assign wait_over    = wait_total > FREE_MIN_V;
  assign wait_at_free = wait_total >= FREE_MIN_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_used_q <= 1'b0;
      wait_used_q <= 1'b0;
      km_done_q   <= 1'b0;
      min_done_q  <= 1'b0;
    end else if (clr) begin
      dist_used_q <= 1'b0;
      wait_used_q <= 1'b0;
      km_done_q   <= 1'b0;
      min_done_q  <= 1'b0;
    end else begin
      dist_used_q <= dist_used_q | dist_over | dist_carry[DIST_DIGITS];
      wait_used_q <= wait_used_q | wait_over | wait_carry[WAIT_DIGITS];
      km_done_q   <= dist_carry[1] & (dist_used_q | dist_over);
      min_done_q  <= wait_inc & (wait_used_q | wait_at_free);
    end
  end

  assign dist_tenths   = dist_dig[0];
  assign dist_km_ones  = dist_dig[1];
  assign dist_km_tens  = dist_dig[2];
  assign wait_min_ones = wait_dig[0];
  assign wait_min_tens = wait_dig[1];
  assign dist_rate_en  = trip_on & ~wait_mode & (dist_used_q | dist_over);
  assign wait_rate_en  = trip_on &  wait_mode & (wait_used_q | wait_over);
  assign km_done       = km_done_q;
  assign min_done      = min_done_q;

  // R2: a low trip_on empties the meter on the next edge
  a_r2_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_on |=> (dist_tenths == 4'd0 && dist_km_ones == 4'd0 &&
                  dist_km_tens == 4'd0 && wait_min_ones == 4'd0 &&
                  wait_min_tens == 4'd0 && !km_done && !min_done));
  // R3: wait mode freezes the distance
  a_r3_wait_holds_distance: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_on && wait_mode) |=> $stable({dist_km_tens, dist_km_ones, dist_tenths}));
  // R4: driving freezes the waiting count
  a_r4_drive_holds_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_on && !wait_mode) |=> $stable({wait_min_tens, wait_min_ones}));
  // R5: tenths wrap and kilometre carry on one edge
  a_r5_tenth_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (dist_inc && dist_tenths == 4'd9) |=>
      (dist_tenths == 4'd0 && {dist_km_tens, dist_km_ones} != $past({dist_km_tens, dist_km_ones})));
  // R10: strobes never coincide, and a km strobe only beyond the allowance
  a_r10_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({km_done, min_done}));
  a_r10_km_beyond_free: assert property (@(posedge clk) disable iff (!rst_n)
    km_done |-> (dist_used_q || dist_over));
endmodule

// File: tb/tb_trip_distance_wait_meter.sv
`timescale 1ns/1ps
module tb_trip_distance_wait_meter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip_on = 1'b0;
  logic wait_mode = 1'b0;
  logic dist_pulse_in = 1'b0;
  logic minute_tick_in = 1'b0;
  logic [3:0] dist_tenths, dist_km_ones, dist_km_tens, wait_min_ones, wait_min_tens;
  logic dist_rate_en, wait_rate_en, km_done, min_done;

  int checks = 0;
  int errors = 0;
  int km_strobes = 0;
  int min_strobes = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  trip_distance_wait_meter dut (
    .clk(clk), .rst_n(rst_n), .trip_on(trip_on), .wait_mode(wait_mode),
    .dist_pulse_in(dist_pulse_in), .minute_tick_in(minute_tick_in),
    .dist_tenths(dist_tenths), .dist_km_ones(dist_km_ones), .dist_km_tens(dist_km_tens),
    .wait_min_ones(wait_min_ones), .wait_min_tens(wait_min_tens),
    .dist_rate_en(dist_rate_en), .wait_rate_en(wait_rate_en),
    .km_done(km_done), .min_done(min_done));

  always @(posedge clk) begin
    if (km_done)  km_strobes++;
    if (min_done) min_strobes++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dist_now();
    return int'(dist_km_tens) * 100 + int'(dist_km_ones) * 10 + int'(dist_tenths);
  endfunction

  function automatic int wait_now();
    return int'(wait_min_tens) * 10 + int'(wait_min_ones);
  endfunction

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wheel(int n, int hold = 3);
    for (int i = 0; i < n; i++) begin
      dist_pulse_in = 1'b1; cycles(hold);
      dist_pulse_in = 1'b0; cycles(3);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      minute_tick_in = 1'b1; cycles(3);
      minute_tick_in = 1'b0; cycles(3);
    end
  endtask

  task automatic clear_trip();
    trip_on = 1'b0; cycles(2);
    trip_on = 1'b1; cycles(1);
  endtask

  task automatic t_reset();
    cycles(3);
    chk("R11 distance after reset", dist_now(), 0);
    chk("R11 waiting after reset", wait_now(), 0);
    chk("R11 flags/strobes after reset",
        int'({dist_rate_en, wait_rate_en, km_done, min_done}), 0);
    rst_n = 1'b1; cycles(2);
  endtask

  task automatic t_drive_threshold();
    int k0;
    trip_on = 1'b1; wait_mode = 1'b0; cycles(2);
    k0 = km_strobes;
    wheel(1, 12);
    chk("R1 long pulse counted once", dist_now(), 1);
    wheel(14);
    chk("R5 fifteen pulses read 01.5", dist_now(), 15);
    wheel(5);
    chk("R8 exactly 2.0 km no rate", int'(dist_rate_en), 0);
    chk("R5 twenty pulses read 02.0", dist_now(), 20);
    wheel(1);
    chk("R8 rate after 21st pulse", int'(dist_rate_en), 1);
    chk("R10 no km strobe within allowance", km_strobes - k0, 0);
    wheel(9);
    chk("R5 thirty pulses read 03.0", dist_now(), 30);
    chk("R10 one km strobe at 3rd km", km_strobes - k0, 1);
  endtask

  task automatic t_wait_mode();
    int m0;
    m0 = min_strobes;
    wait_mode = 1'b1; cycles(1);
    chk("R8 distance rate low in wait mode", int'(dist_rate_en), 0);
    wheel(5);
    chk("R3 pulses ignored while waiting", dist_now(), 30);
    tick(2);
    chk("R4 two ticks two minutes", wait_now(), 2);
    chk("R9 no wait rate at 2 min", int'(wait_rate_en), 0);
    chk("R10 no min strobe within allowance", min_strobes - m0, 0);
    tick(1);
    chk("R9 wait rate after 3rd minute", int'(wait_rate_en), 1);
    chk("R10 one min strobe at 3rd minute", min_strobes - m0, 1);
    wait_mode = 1'b0; cycles(1);
    chk("R9 wait rate low while driving", int'(wait_rate_en), 0);
    chk("R8 distance rate back while driving", int'(dist_rate_en), 1);
    tick(2);
    chk("R4 ticks ignored while driving", wait_now(), 3);
  endtask

  task automatic t_clear();
    trip_on = 1'b0; cycles(2);
    chk("R2 distance cleared", dist_now(), 0);
    chk("R2 waiting cleared", wait_now(), 0);
    chk("R2 flags low", int'({dist_rate_en, wait_rate_en}), 0);
    wheel(2);
    chk("R2 pulses ignored while trip off", dist_now(), 0);
    trip_on = 1'b1; cycles(1);
    chk("R2 allowance record cleared", int'(dist_rate_en), 0);
  endtask

  task automatic t_km_wrap();
    int k0;
    clear_trip();
    wait_mode = 1'b0;
    k0 = km_strobes;
    wheel(999);
    chk("R6 999 pulses read 99.9", dist_now(), 999);
    wheel(1);
    chk("R6 R5 wrap to 00.0", dist_now(), 0);
    chk("R8 rate kept after wrap", int'(dist_rate_en), 1);
    chk("R10 km strobes for km 3..100", km_strobes - k0, 98);
  endtask

  task automatic t_min_wrap();
    int m0;
    clear_trip();
    wait_mode = 1'b1; cycles(1);
    m0 = min_strobes;
    tick(59);
    chk("R7 59 ticks read 59", wait_now(), 59);
    tick(1);
    chk("R7 wrap to 00", wait_now(), 0);
    chk("R9 wait rate kept after wrap", int'(wait_rate_en), 1);
    chk("R10 min strobes for minutes 3..60", min_strobes - m0, 58);
  endtask

  initial begin
    t_reset();
    t_drive_threshold();
    t_wait_mode();
    t_clear();
    t_km_wrap();
    t_min_wrap();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule